// File: doc/BRIEF.md
# Bus Timeout Decrementer

This block times a bus access, or the window in which a transient error may still be reported. A start strobe loads a 24-bit down-counter. The top byte of the load comes from a software-programmable duration register, and the low 16 bits take the fixed value 128. The counter then drops by one on every clock until it reaches zero or a done strobe stops it. When it reaches zero, the block emits a single-cycle expiry pulse. It also emits a timeout error pulse. A diagnostic mode suppresses that error for accesses that are not local to the node.

Software writes the duration through an 8-bit port. It reads back the same 8-bit field. While a count runs, the readback shows the live upper byte of the counter. While idle, it shows the programmed duration. After reset the duration is zero, so the shortest timeout of 128 cycles applies until configuration lengthens it.

Top module: `bus_tmo_dec`

## Requirements
- R1: After reset the duration register is 0, the counter is idle, `busy_o`, `expire_o` and `tmo_err_o` are 0, and `rd_data_o` reads 0.
- R2: A start loads the counter with the duration in bits 23:16 and 128 in bits 15:0. With duration D, `expire_o` is high in the cycle that follows the clock edge lying D*65536+128 edges after the start edge.
- R3: While running and not started or stopped, the counter decreases by exactly one per clock.
- R4: Expiry is a pulse exactly one cycle wide, produced when the count goes from 1 to 0. The counter then stays at zero with `busy_o` low.
- R5: `rd_data_o` gives the counter's bits 23:16 while `busy_o` is high, and the duration register while idle.
- R6: A start while running reloads the counter at once, with no expiry from the earlier count. If start and stop arrive together, start wins.
- R7: A stop strobe without a start ends the count, clears the counter, and produces no expiry.
- R8: A duration write takes effect only at the next start and never alters a count in progress. A start in the same cycle as a write loads the old duration.
- R9: `tmo_err_o` is high together with `expire_o`, except when `diag_mode_i` is high at expiry and `nonlocal_i` was high at the start that began the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Component clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load counter and begin timing |
| stop_i | input | 1 | Access done: stop without expiry |
| nonlocal_i | input | 1 | Access being timed is not local to the node (sampled at start) |
| diag_mode_i | input | 1 | Diagnostic mode: masks the error for non-local accesses |
| wr_en_i | input | 1 | Write strobe for the duration register |
| wr_data_i | input | 8 | Duration write data |
| rd_data_o | output | 8 | Live counter bits 23:16 when busy, duration when idle |
| busy_o | output | 1 | Counter running |
| expire_o | output | 1 | One-cycle expiry pulse |
| tmo_err_o | output | 1 | Timeout error pulse after masking |

## Verification
The counting path is run with duration 0 under every combination of the non-local and diagnostic inputs. These runs fix the 128-cycle floor and show that the error is masked only in the one combination that should mask it. A run with duration 1 gives 65,664 cycles and shows that the programmed byte really lands in bits 23:16. It also shows the readback changing from the programmed byte to the live counter byte. Directed runs use a stop mid-count, a restart mid-count, start together with stop, and a duration write mid-count. They separate a counter that resets its timing from one that keeps the old count, and a write that acts now from one that waits for the next start.

// File: rtl/bus_tmo_pkg.sv
package bus_tmo_pkg;
  parameter int CNT_W    = 24;
  parameter int DUR_W    = 8;
  parameter int LOW_SEED = 128;
endpackage

// File: rtl/bus_tmo_dur_reg.sv
module bus_tmo_dur_reg #(
  parameter int DUR_W = bus_tmo_pkg::DUR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DUR_W-1:0] wr_data_i,
  output logic [DUR_W-1:0] dur_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dur_o <= '0;
    else if (wr_en_i) dur_o <= wr_data_i;
  end

  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> dur_o == $past(wr_data_i));
endmodule

// File: rtl/bus_tmo_counter.sv
module bus_tmo_counter #(
  parameter int CNT_W    = bus_tmo_pkg::CNT_W,
  parameter int DUR_W    = bus_tmo_pkg::DUR_W,
  parameter int LOW_SEED = bus_tmo_pkg::LOW_SEED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             busy_o,
  output logic             expire_o,
  output logic [DUR_W-1:0] cnt_hi_o
);
  localparam int LOW_W = CNT_W - DUR_W;
  localparam logic [LOW_W-1:0] SEED = LOW_W'(LOW_SEED);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (start_i) begin
        cnt_q <= {dur_i, SEED};
        run_q <= 1'b1;
      end else if (stop_i) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else if (run_q) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) begin
          run_q <= 1'b0;
          exp_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o   = run_q;
  assign expire_o = exp_q;
  assign cnt_hi_o = cnt_q[CNT_W-1 -: DUR_W];

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && cnt_q[CNT_W-1 -: DUR_W] == $past(dur_i)
                && cnt_q[LOW_W-1:0] == SEED);
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !start_i && !stop_i |=> cnt_q == $past(cnt_q) - ONE);
  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> cnt_q == '0 && !busy_o);
  a_r6_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !expire_o);
  a_r7_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !busy_o && !expire_o);
endmodule

// File: rtl/bus_tmo_err_mask.sv
module bus_tmo_err_mask (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic nonlocal_i,
  input  logic diag_mode_i,
  input  logic expire_i,
  output logic err_o
);
  logic nonlocal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      nonlocal_q <= 1'b0;
    else if (start_i) nonlocal_q <= nonlocal_i;
  end

  // diagnostic mode only hides timeouts of non-local accesses
  assign err_o = expire_i && !(diag_mode_i && nonlocal_q);

  a_r9_err_needs_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> expire_i);
  a_r9_local_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && !diag_mode_i |-> err_o);
endmodule

// File: rtl/bus_tmo_dec.sv
module bus_tmo_dec #(
  parameter int CNT_W    = bus_tmo_pkg::CNT_W,
  parameter int DUR_W    = bus_tmo_pkg::DUR_W,
  parameter int LOW_SEED = bus_tmo_pkg::LOW_SEED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             nonlocal_i,
  input  logic             diag_mode_i,
  input  logic             wr_en_i,
  input  logic [DUR_W-1:0] wr_data_i,
  output logic [DUR_W-1:0] rd_data_o,
  output logic             busy_o,
  output logic             expire_o,
  output logic             tmo_err_o
);
  logic [DUR_W-1:0] dur;
  logic [DUR_W-1:0] cnt_hi;

  bus_tmo_dur_reg #(.DUR_W(DUR_W)) u_dur (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .dur_o(dur)
  );

  bus_tmo_counter #(.CNT_W(CNT_W), .DUR_W(DUR_W), .LOW_SEED(LOW_SEED)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .dur_i(dur), .busy_o(busy_o), .expire_o(expire_o), .cnt_hi_o(cnt_hi)
  );

  bus_tmo_err_mask u_err (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .nonlocal_i(nonlocal_i),
    .diag_mode_i(diag_mode_i), .expire_i(expire_o), .err_o(tmo_err_o)
  );

  assign rd_data_o = busy_o ? cnt_hi : dur;

  a_r5_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !start_i && !busy_o |=> !busy_o |-> rd_data_o == $past(wr_data_i));
endmodule

// File: tb/bus_tmo_dec_tb.sv
module bus_tmo_dec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 5;
  localparam logic [7:0] V_DUR  [N_VEC] = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd1};
  localparam logic       V_NLOC [N_VEC] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic       V_DIAG [N_VEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int         V_LEN  [N_VEC] = '{128, 128, 128, 128, 65664};
  localparam logic       V_ERR  [N_VEC] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, nloc = 1'b0, diag = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic busy, expire, err;
  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_tmo_dec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .nonlocal_i(nloc), .diag_mode_i(diag), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .busy_o(busy),
    .expire_o(expire), .tmo_err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic write_dur(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  // count negedges after the last start edge until expire_o is seen
  task automatic wait_exp(input int base, input int lim, output int k);
    k = base;
    do begin
      @(negedge clk);
      k++;
    end while (!expire && k < lim);
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 expire", expire, 0);
    chk("R1 err", err, 0);
    chk("R1 rd", rd_data, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      write_dur(V_DUR[i]);
      chk("R5 idle read", rd_data, V_DUR[i]);
      @(negedge clk) begin nloc = V_NLOC[i]; diag = V_DIAG[i]; end
      pulse_start();
      nloc = 1'b0;
      @(negedge clk);
      chk("R5 live read", rd_data, V_DUR[i]);
      chk("R3 busy", busy, 1);
      wait_exp(1, 70000, k);
      chk("R2 length", k, V_LEN[i]);
      chk("R9 err", err, V_ERR[i]);
      chk("R4 busy low", busy, 0);
      @(negedge clk);
      chk("R4 one cycle", expire, 0);
      diag = 1'b0;
    end

    // R5: live byte decays below duration; duration 1 -> upper byte 0 after 200
    write_dur(8'd1);
    pulse_start();
    repeat (200) @(negedge clk);
    chk("R5 decayed", rd_data, 0);
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    chk("R7 stopped", busy, 0);
    chk("R5 idle after stop", rd_data, 1);
    write_dur(8'd0);

    // R7: stop mid-count, no expiry ever
    pulse_start();
    repeat (50) @(negedge clk);
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    wait_exp(0, 300, k);
    chk("R7 no expire", expire, 0);
    chk("R7 idle", busy, 0);

    // R6: restart after 100 cycles, expiry 128 after the new start
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    wait_exp(0, 300, k);
    chk("R6 restart length", k, 128);

    // R6: start and stop together -> start wins
    @(negedge clk) begin start = 1'b1; stop = 1'b1; end
    @(negedge clk) begin start = 1'b0; stop = 1'b0; end
    wait_exp(0, 300, k);
    chk("R6 start wins", k, 128);

    // R8: write during count leaves it alone
    pulse_start();
    repeat (9) @(negedge clk);
    write_dur(8'd3);
    wait_exp(11, 300, k);
    chk("R8 count kept", k, 128);
    chk("R8 new value idle", rd_data, 3);
    write_dur(8'd0);

    // R8: same-cycle write and start loads old duration (0)
    @(negedge clk) begin start = 1'b1; wr_en = 1'b1; wr_data = 8'd2; end
    @(negedge clk) begin start = 1'b0; wr_en = 1'b0; end
    wait_exp(0, 300, k);
    chk("R8 old loaded", k, 128);
    chk("R8 reg updated", rd_data, 2);

    finish_run();
  end
endmodule